// File: doc/BRIEF.md
# Chunked Copy Command Generator

This block turns one copy request into a stream of commands for a downstream copy engine. A request is either a two-dimensional rectangle or a flat run of bytes. For a rectangle, the request gives a base offset, a row pitch, a top-left coordinate and a bytes-per-pixel value for the source, and the same for the destination, plus a width and a height. For a flat run, it gives two byte offsets and a byte count. The block works out the first source and destination offsets. It then cuts the work into pieces that the engine can take in one command.

Each piece leaves the block as three beats on a valid/ready output. The first is a copy beat that carries the two offsets, the two pitches, the line length in bytes and the line count. A no-op beat and a flush beat follow it. The next piece starts only after the flush beat has been accepted. A single-cycle `done` pulse marks the end of the request. While a request is in progress, `req_ready` stays low.

Top module: `copy_cmd_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: In rectangle mode, the first copy beat has source offset = src_base + src_y*src_pitch + src_x*src_bpp. The destination offset is formed the same way from the destination fields. Both pitches are passed through unchanged.
- R3: In rectangle mode, the line length is width times the source bytes per pixel. The destination bytes per pixel has no effect on it.
- R4: A copy beat never carries more than 2047 lines, and never carries zero lines. A rectangle of height H produces ceil(H/2047) copy beats, with line counts 2047, 2047, ..., and the remainder last.
- R5: For each copy beat after the first, each offset equals the previous offset plus that side's pitch times the previous line count (modulo 2^32).
- R6: In linear mode, the whole 4096-byte pages are sent first. Each copy beat has line length 4096, both pitches 4096, and at most 2047 lines. Both offsets advance by 4096 times the lines of the previous beat.
- R7: In linear mode, if size mod 4096 is non-zero, one last copy beat carries 1 line. Its line length and both pitches equal that remainder, and its offsets follow on from the page beats. If the remainder is zero, no such beat is sent.
- R8: Beat kind is encoded on `cmd_kind` as 1 = copy, 2 = no-op, 3 = flush. Every accepted copy beat is followed by a no-op and then a flush. No-op and flush beats carry zero in every data field.
- R9: While `cmd_valid` is 1 and `cmd_ready` is 0, the beat on the output stays unchanged on the next cycle.
- R10: `done` is high for exactly the cycle after the final flush beat is accepted. `req_ready` is 0 whenever `cmd_valid` is 1.
- R11: A rectangle of height 0, or a linear request of size 0, produces no beats. It raises `done` in the cycle after the request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on valid & ready |
| req_linear | input | 1 | 1 = flat byte run, 0 = rectangle |
| req_src_base | input | 32 | Source base offset in bytes |
| req_dst_base | input | 32 | Destination base offset in bytes |
| req_src_pitch | input | 16 | Source row pitch in bytes |
| req_dst_pitch | input | 16 | Destination row pitch in bytes |
| req_src_x | input | 12 | Source left column |
| req_src_y | input | 12 | Source top row |
| req_dst_x | input | 12 | Destination left column |
| req_dst_y | input | 12 | Destination top row |
| req_width | input | 12 | Rectangle width in pixels |
| req_height | input | 12 | Rectangle height in rows |
| req_src_bpp | input | 3 | Source bytes per pixel |
| req_dst_bpp | input | 3 | Destination bytes per pixel |
| req_size | input | 32 | Byte count for linear mode |
| cmd_valid | output | 1 | Beat offered |
| cmd_ready | input | 1 | Engine accepts the beat |
| cmd_kind | output | 2 | 1 copy, 2 no-op, 3 flush |
| cmd_src_off | output | 32 | Source offset of the copy |
| cmd_dst_off | output | 32 | Destination offset of the copy |
| cmd_src_pitch | output | 16 | Source pitch |
| cmd_dst_pitch | output | 16 | Destination pitch |
| cmd_line_len | output | 15 | Bytes per line |
| cmd_line_cnt | output | 11 | Lines in this copy |
| done | output | 1 | One-cycle pulse, request finished |

## Verification
The bench targets the boundaries of the line limit. Heights of exactly 2047 and 2048 show whether a design clamps off by one: it would send a 2048-line beat, or an extra empty one. A run of 2049 pages plus a few bytes checks that the remainder beat picks up the advanced offsets. A design that dropped the advance would rewrite the first page. Page-aligned sizes check that no zero-length tail is sent. Empty requests check that `done` still fires without any beats. A throttled `cmd_ready` catches a design that changes the beat, or skips the no-op, while it is stalled.

// File: rtl/copy_cmd_pkg.sv
package copy_cmd_pkg;

    parameter int ADDR_W     = 32;
    parameter int PITCH_W    = 16;
    parameter int COORD_W    = 12;
    parameter int BPP_W      = 3;
    parameter int SIZE_W     = 32;
    parameter int PAGE_SHIFT = 12;
    parameter int MAX_LINES  = 2047;

    localparam int PAGE_BYTES = 1 << PAGE_SHIFT;
    localparam int CNT_W      = $clog2(MAX_LINES + 1);
    localparam int PAGES_W    = SIZE_W - PAGE_SHIFT;
    localparam int LINES_W    = (PAGES_W > COORD_W) ? PAGES_W : COORD_W;
    localparam int LEN_W      = ((COORD_W + BPP_W) > (PAGE_SHIFT + 1)) ?
                                (COORD_W + BPP_W) : (PAGE_SHIFT + 1);

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [PITCH_W-1:0] pitch_t;
    typedef logic [LEN_W-1:0]   len_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [LINES_W-1:0] lines_t;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_COPY  = 2'd1,
        KIND_NOP   = 2'd2,
        KIND_FLUSH = 2'd3
    } cmd_kind_e;

    // Work still owed for the request in flight.
    typedef struct packed {
        addr_t                 src_off;
        addr_t                 dst_off;
        pitch_t                src_pitch;
        pitch_t                dst_pitch;
        len_t                  line_len;
        lines_t                lines_left;
        logic [PAGE_SHIFT-1:0] tail_len;
    } job_t;

    // One beat on the command output.
    typedef struct packed {
        cmd_kind_e kind;
        addr_t     src_off;
        addr_t     dst_off;
        pitch_t    src_pitch;
        pitch_t    dst_pitch;
        len_t      line_len;
        cnt_t      line_cnt;
    } cmd_t;

    function automatic addr_t corner_offset(input addr_t base,
                                            input pitch_t pitch,
                                            input logic [COORD_W-1:0] x,
                                            input logic [COORD_W-1:0] y,
                                            input logic [BPP_W-1:0] bpp);
        addr_t row_part;
        addr_t col_part;
        row_part = ADDR_W'(y) * ADDR_W'(pitch);
        col_part = ADDR_W'(x) * ADDR_W'(bpp);
        return base + row_part + col_part;
    endfunction

    function automatic cnt_t clamp_lines(input lines_t left);
        if (left > LINES_W'(MAX_LINES))
            return CNT_W'(MAX_LINES);
        return left[CNT_W-1:0];
    endfunction

endpackage

// File: rtl/copy_cmd_setup.sv
module copy_cmd_setup
    import copy_cmd_pkg::*;
(
    input  logic               linear,
    input  addr_t              src_base,
    input  addr_t              dst_base,
    input  pitch_t             src_pitch,
    input  pitch_t             dst_pitch,
    input  logic [COORD_W-1:0] src_x,
    input  logic [COORD_W-1:0] src_y,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    input  logic [COORD_W-1:0] width,
    input  logic [COORD_W-1:0] height,
    input  logic [BPP_W-1:0]   src_bpp,
    input  logic [BPP_W-1:0]   dst_bpp,
    input  logic [SIZE_W-1:0]  size,
    output job_t               job,
    output logic               empty
);

    always_comb begin
        if (linear) begin
            job.src_off    = src_base;
            job.dst_off    = dst_base;
            job.src_pitch  = PITCH_W'(PAGE_BYTES);
            job.dst_pitch  = PITCH_W'(PAGE_BYTES);
            job.line_len   = LEN_W'(PAGE_BYTES);
            job.lines_left = LINES_W'(size[SIZE_W-1:PAGE_SHIFT]);
            job.tail_len   = size[PAGE_SHIFT-1:0];
        end else begin
            job.src_off    = corner_offset(src_base, src_pitch, src_x, src_y, src_bpp);
            job.dst_off    = corner_offset(dst_base, dst_pitch, dst_x, dst_y, dst_bpp);
            job.src_pitch  = src_pitch;
            job.dst_pitch  = dst_pitch;
            job.line_len   = LEN_W'(width) * LEN_W'(src_bpp);
            job.lines_left = LINES_W'(height);
            job.tail_len   = '0;
        end
        empty = (job.lines_left == '0) && (job.tail_len == '0);
    end

endmodule

// File: rtl/copy_cmd_chunk.sv
module copy_cmd_chunk
    import copy_cmd_pkg::*;
(
    input  job_t      job,
    input  cmd_kind_e beat,
    output cmd_t      cmd,
    output cnt_t      piece_lines,
    output logic      is_tail
);

    always_comb begin
        is_tail     = (job.lines_left == '0);
        piece_lines = is_tail ? cnt_t'(1) : clamp_lines(job.lines_left);
        cmd         = '0;
        cmd.kind    = beat;
        if (beat == KIND_COPY) begin
            cmd.src_off  = job.src_off;
            cmd.dst_off  = job.dst_off;
            cmd.line_cnt = piece_lines;
            if (is_tail) begin
                cmd.src_pitch = PITCH_W'(job.tail_len);
                cmd.dst_pitch = PITCH_W'(job.tail_len);
                cmd.line_len  = LEN_W'(job.tail_len);
            end else begin
                cmd.src_pitch = job.src_pitch;
                cmd.dst_pitch = job.dst_pitch;
                cmd.line_len  = job.line_len;
            end
        end
    end

endmodule

// File: rtl/copy_cmd_seq.sv
module copy_cmd_seq
    import copy_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    output logic      req_ready,
    input  job_t      setup_job,
    input  logic      setup_empty,
    input  logic      cmd_ready,
    input  cnt_t      piece_lines,
    input  logic      is_tail,
    output cmd_kind_e beat,
    output job_t      job,
    output logic      done
);

    typedef enum logic [1:0] {ST_IDLE, ST_COPY, ST_NOP, ST_FLUSH} state_e;

    state_e state;
    job_t   next_job;
    logic   last_piece;

    assign req_ready = (state == ST_IDLE);

    always_comb begin
        case (state)
            ST_COPY:  beat = KIND_COPY;
            ST_NOP:   beat = KIND_NOP;
            ST_FLUSH: beat = KIND_FLUSH;
            default:  beat = KIND_NONE;
        endcase
    end

    // Bookkeeping once a piece's flush has gone out.
    always_comb begin
        next_job = job;
        if (is_tail) begin
            next_job.tail_len = '0;
        end else begin
            next_job.lines_left = job.lines_left - LINES_W'(piece_lines);
            next_job.src_off    = job.src_off + ADDR_W'(job.src_pitch) * ADDR_W'(piece_lines);
            next_job.dst_off    = job.dst_off + ADDR_W'(job.dst_pitch) * ADDR_W'(piece_lines);
        end
        last_piece = (next_job.lines_left == '0) && (next_job.tail_len == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            job   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        job <= setup_job;
                        if (setup_empty) done  <= 1'b1;
                        else             state <= ST_COPY;
                    end
                end
                ST_COPY:  if (cmd_ready) state <= ST_NOP;
                ST_NOP:   if (cmd_ready) state <= ST_FLUSH;
                ST_FLUSH: begin
                    if (cmd_ready) begin
                        job <= next_job;
                        if (last_piece) begin
                            state <= ST_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= ST_COPY;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: done only ever leaves an idle state behind it
    a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == ST_IDLE));

    // R4: remaining work never grows while a piece is in flight
    a_r4_lines_shrink: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FLUSH && cmd_ready && !is_tail) |=> (job.lines_left < $past(job.lines_left)));

endmodule

// File: rtl/copy_cmd_gen.sv
module copy_cmd_gen
    import copy_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_linear,
    input  logic [ADDR_W-1:0]  req_src_base,
    input  logic [ADDR_W-1:0]  req_dst_base,
    input  logic [PITCH_W-1:0] req_src_pitch,
    input  logic [PITCH_W-1:0] req_dst_pitch,
    input  logic [COORD_W-1:0] req_src_x,
    input  logic [COORD_W-1:0] req_src_y,
    input  logic [COORD_W-1:0] req_dst_x,
    input  logic [COORD_W-1:0] req_dst_y,
    input  logic [COORD_W-1:0] req_width,
    input  logic [COORD_W-1:0] req_height,
    input  logic [BPP_W-1:0]   req_src_bpp,
    input  logic [BPP_W-1:0]   req_dst_bpp,
    input  logic [SIZE_W-1:0]  req_size,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [1:0]         cmd_kind,
    output logic [ADDR_W-1:0]  cmd_src_off,
    output logic [ADDR_W-1:0]  cmd_dst_off,
    output logic [PITCH_W-1:0] cmd_src_pitch,
    output logic [PITCH_W-1:0] cmd_dst_pitch,
    output logic [LEN_W-1:0]   cmd_line_len,
    output logic [CNT_W-1:0]   cmd_line_cnt,
    output logic               done
);

    job_t      setup_job;
    logic      setup_empty;
    job_t      cur_job;
    cmd_kind_e beat;
    cmd_t      cmd;
    cnt_t      piece_lines;
    logic      is_tail;

    copy_cmd_setup u_setup (
        .linear    (req_linear),
        .src_base  (req_src_base),
        .dst_base  (req_dst_base),
        .src_pitch (req_src_pitch),
        .dst_pitch (req_dst_pitch),
        .src_x     (req_src_x),
        .src_y     (req_src_y),
        .dst_x     (req_dst_x),
        .dst_y     (req_dst_y),
        .width     (req_width),
        .height    (req_height),
        .src_bpp   (req_src_bpp),
        .dst_bpp   (req_dst_bpp),
        .size      (req_size),
        .job       (setup_job),
        .empty     (setup_empty)
    );

    copy_cmd_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .setup_job   (setup_job),
        .setup_empty (setup_empty),
        .cmd_ready   (cmd_ready),
        .piece_lines (piece_lines),
        .is_tail     (is_tail),
        .beat        (beat),
        .job         (cur_job),
        .done        (done)
    );

    copy_cmd_chunk u_chunk (
        .job         (cur_job),
        .beat        (beat),
        .cmd         (cmd),
        .piece_lines (piece_lines),
        .is_tail     (is_tail)
    );

    assign cmd_valid     = (beat != KIND_NONE);
    assign cmd_kind      = cmd.kind;
    assign cmd_src_off   = cmd.src_off;
    assign cmd_dst_off   = cmd.dst_off;
    assign cmd_src_pitch = cmd.src_pitch;
    assign cmd_dst_pitch = cmd.dst_pitch;
    assign cmd_line_len  = cmd.line_len;
    assign cmd_line_cnt  = cmd.line_cnt;

    // R4: copy beats carry between 1 and the line limit
    a_r4_line_limit: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == KIND_COPY) |->
            (cmd_line_cnt != '0 && cmd_line_cnt <= CNT_W'(MAX_LINES)));

    // R8: copy accepted -> no-op offered next
    a_r8_copy_then_nop: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_kind == KIND_COPY) |=> (cmd_valid && cmd_kind == KIND_NOP));

    // R8: no-op accepted -> flush offered next
    a_r8_nop_then_flush: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_kind == KIND_NOP) |=> (cmd_valid && cmd_kind == KIND_FLUSH));

    // R9: a stalled beat does not move
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=>
            (cmd_valid && $stable(cmd_kind) && $stable(cmd_src_off) && $stable(cmd_dst_off)
             && $stable(cmd_line_cnt) && $stable(cmd_line_len)));

    // R10: no new request while beats are pending
    a_r10_busy: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> !req_ready);

    // R10/R11: done follows a final flush or an empty request
    a_r10_done_cause: assert property (@(posedge clk) disable iff (rst)
        done |-> $past((cmd_valid && cmd_ready && cmd_kind == KIND_FLUSH) || (req_valid && req_ready)));

endmodule

// File: tb/tb_copy_cmd_gen.sv
module tb_copy_cmd_gen;
    import copy_cmd_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic               req_linear = 1'b0;
    logic [ADDR_W-1:0]  req_src_base = '0, req_dst_base = '0;
    logic [PITCH_W-1:0] req_src_pitch = '0, req_dst_pitch = '0;
    logic [COORD_W-1:0] req_src_x = '0, req_src_y = '0, req_dst_x = '0, req_dst_y = '0;
    logic [COORD_W-1:0] req_width = '0, req_height = '0;
    logic [BPP_W-1:0]   req_src_bpp = '0, req_dst_bpp = '0;
    logic [SIZE_W-1:0]  req_size = '0;
    logic               cmd_valid;
    logic               cmd_ready = 1'b1;
    logic [1:0]         cmd_kind;
    logic [ADDR_W-1:0]  cmd_src_off, cmd_dst_off;
    logic [PITCH_W-1:0] cmd_src_pitch, cmd_dst_pitch;
    logic [LEN_W-1:0]   cmd_line_len;
    logic [CNT_W-1:0]   cmd_line_cnt;
    logic               done;

    copy_cmd_gen dut (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic [1:0]         kind;
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  dst;
        logic [PITCH_W-1:0] sp;
        logic [PITCH_W-1:0] dp;
        logic [LEN_W-1:0]   len;
        logic [CNT_W-1:0]   cnt;
    } beat_t;

    beat_t exp_q[$];
    string tag_q[$];

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_event = -1;
    int done_cnt = 0;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'h5a;
    logic  prev_stall = 1'b0;
    beat_t prev_got;
    string done_tag = "R10";

    always @(posedge clk) cyc++;

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] k, input logic [31:0] s, input logic [31:0] d,
                        input int sp, input int dp, input int len, input int cnt, input string tag);
        beat_t b;
        b.kind = k; b.src = s; b.dst = d;
        b.sp = PITCH_W'(sp); b.dp = PITCH_W'(dp);
        b.len = LEN_W'(len); b.cnt = CNT_W'(cnt);
        exp_q.push_back(b); tag_q.push_back(tag);
        if (k == 2'd1) begin
            exp_q.push_back('{kind: 2'd2, default: '0}); tag_q.push_back("R8");
            exp_q.push_back('{kind: 2'd3, default: '0}); tag_q.push_back("R8");
        end
    endtask

    task automatic issue_and_wait();
        int target;
        target = done_cnt + 1;
        @(negedge clk);
        req_valid = 1'b1;
        last_event = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt < target) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_rect(input logic [31:0] sb, input logic [31:0] db, input int sp, input int dp,
                            input int sx, input int sy, input int dx, input int dy,
                            input int w, input int h, input int sbpp, input int dbpp, input string tag);
        logic [31:0] s, d;
        int left, n;
        bit first;
        s = sb + 32'(sy) * 32'(sp) + 32'(sx) * 32'(sbpp);
        d = db + 32'(dy) * 32'(dp) + 32'(dx) * 32'(dbpp);
        left = h; first = 1;
        while (left > 0) begin
            n = (left > 2047) ? 2047 : left;
            push(2'd1, s, d, sp, dp, w * sbpp, n, first ? tag : "R5");
            s = s + 32'(sp) * 32'(n);
            d = d + 32'(dp) * 32'(n);
            left -= n; first = 0;
        end
        done_tag = (h == 0) ? "R11" : "R10";
        req_linear = 1'b0;
        req_src_base = sb; req_dst_base = db;
        req_src_pitch = PITCH_W'(sp); req_dst_pitch = PITCH_W'(dp);
        req_src_x = COORD_W'(sx); req_src_y = COORD_W'(sy);
        req_dst_x = COORD_W'(dx); req_dst_y = COORD_W'(dy);
        req_width = COORD_W'(w); req_height = COORD_W'(h);
        req_src_bpp = BPP_W'(sbpp); req_dst_bpp = BPP_W'(dbpp);
        req_size = 32'hdead_0000;
        issue_and_wait();
    endtask

    task automatic run_linear(input logic [31:0] sb, input logic [31:0] db, input int size);
        logic [31:0] s, d;
        int pages, n, rem;
        s = sb; d = db;
        pages = size / 4096; rem = size % 4096;
        while (pages > 0) begin
            n = (pages > 2047) ? 2047 : pages;
            push(2'd1, s, d, 4096, 4096, 4096, n, "R6");
            s = s + 32'(n) * 32'd4096;
            d = d + 32'(n) * 32'd4096;
            pages -= n;
        end
        if (rem != 0) push(2'd1, s, d, rem, rem, rem, 1, "R7");
        done_tag = (size == 0) ? "R11" : "R10";
        req_linear = 1'b1;
        req_src_base = sb; req_dst_base = db;
        req_src_pitch = 16'h1234; req_dst_pitch = 16'h0777;
        req_src_x = 12'd5; req_src_y = 12'd9; req_dst_x = 12'd3; req_dst_y = 12'd1;
        req_width = 12'd77; req_height = 12'd0; req_src_bpp = 3'd4; req_dst_bpp = 3'd2;
        req_size = 32'(size);
        issue_and_wait();
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        beat_t got, e;
        string t;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cmd_ready = (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
        #1;
        if (!rst) begin
            got = '{cmd_kind, cmd_src_off, cmd_dst_off, cmd_src_pitch, cmd_dst_pitch,
                    cmd_line_len, cmd_line_cnt};
            if (prev_stall)
                check(cmd_valid && got == prev_got, "R9", "stalled beat changed",
                      128'(got), 128'(prev_got));
            prev_stall = cmd_valid && !cmd_ready;
            prev_got   = got;
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected beat", 128'(got), 128'(0));
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(got == e, t, "beat", 128'(got), 128'(e));
                end
                if (cmd_kind == 2'd3) last_event = cyc + 1;
            end
            if (done) begin
                done_cnt++;
                check(cyc == last_event, done_tag, "done cycle", 128'(cyc), 128'(last_event));
                check(exp_q.size() == 0, done_tag, "beats left at done",
                      128'(exp_q.size()), 128'(0));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state
        check(req_ready == 1'b1, "R1", "req_ready", 128'(req_ready), 128'(1));
        check(cmd_valid == 1'b0, "R1", "cmd_valid", 128'(cmd_valid), 128'(0));
        check(done == 1'b0, "R1", "done", 128'(done), 128'(0));

        // R2 / R3: small rectangle, dst bpp differs from src bpp
        run_rect(32'h0001_0000, 32'h0800_0040, 640, 1024, 3, 7, 10, 2, 20, 5, 4, 2, "R2");
        run_rect(32'h0000_0100, 32'h0000_0000, 96, 200, 0, 0, 5, 5, 30, 3, 1, 4, "R3");
        // R4: exactly at the limit, one over, and two pieces
        run_rect(32'h1000_0000, 32'h2000_0000, 256, 512, 1, 1, 2, 2, 64, 2047, 2, 2, "R4");
        run_rect(32'h0000_0000, 32'h0010_0000, 128, 128, 0, 4, 0, 0, 32, 2048, 4, 4, "R4");
        rdy_mode = 1;
        run_rect(32'hffff_f000, 32'h0000_1000, 4000, 64, 9, 3, 0, 0, 1000, 4000, 4, 1, "R4");
        // R11: empty rectangle
        run_rect(32'h0000_0000, 32'h0000_0000, 64, 64, 0, 0, 0, 0, 10, 0, 4, 4, "R11");
        // R6 / R7: linear forms
        run_linear(32'h0040_0000, 32'h0080_0000, 3 * 4096 + 100);
        run_linear(32'h0000_1234, 32'h0000_5678, 100);
        rdy_mode = 0;
        run_linear(32'h0000_0000, 32'h4000_0000, 2049 * 4096 + 5);
        run_linear(32'h0000_2000, 32'h0000_9000, 2 * 4096);
        run_linear(32'h0000_0000, 32'h0000_0000, 0);

        check(exp_q.size() == 0, "R8", "beats never produced", 128'(exp_q.size()), 128'(0));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule